// File: doc/BRIEF.md
# Timer-Synchronised Stepper Pattern Output

This block drives stepper-motor phase patterns onto eight pins, split into two groups of four. Each group copies a 4-bit pattern from its own data register into an output latch at the moment its timer signals that its count has reached zero. Software can therefore write the next pattern at any time between steps, and the change reaches the pins only on the following step strobe.

Each group can be gated by a pulse-width signal from a second timer. Group 0 also has a polarity control that inverts its whole output, after gating. When a group is not in pulse mode, its pins carry the ordinary port values supplied from outside. Each pin has a flag that shows whether it is in pulse mode. The timers are outside the block: their zero events and their pulse-width waveforms arrive as input signals.

The registers are written and read through a small select/data interface. Mode bit 0 enables group 1 (pins 7..4). Mode bit 1 enables group 0 (pins 3..0). Bit 3 inverts group 0. Bit 4 enables gating on group 0, and bit 5 enables gating on group 1.

Top module: `step_pattern_out`

## Requirements
- R1: Mode bit 0 puts pins 7..4 (group 1) into pulse mode and mode bit 1 puts pins 3..0 (group 0) into pulse mode. Both may be set together. `pin_pulse_en` is 1 exactly on the pins in pulse mode.
- R2: A high `zero_g1` at a clock edge copies bits 3..0 of data register 1 into the group 1 latch, with bit n going to pin 4+n. A 0 gives a low pin and a 1 gives a high pin. The new value appears on the pins right after that edge.
- R3: A high `zero_g0` at a clock edge copies bits 3..0 of data register 0 into the group 0 latch, with bit n going to pin n. A 0 gives a low pin and a 1 gives a high pin. The new value appears right after that edge.
- R4: A data register write does not change the pins until the next zero strobe of its group. A write and a strobe in the same cycle latch the value the register held before that write.
- R5: When mode bit 4 (group 0, `pwm_g0`) or mode bit 5 (group 1, `pwm_g1`) is set, each latched bit of that group is ANDed with the pulse-width input, combinationally.
- R6: Mode bit 3 inverts all four group 0 outputs, and the inversion is applied after gating. Group 1 is never inverted.
- R7: The pins of a group that is not in pulse mode equal the matching `port_in` bits.
- R8: After reset the mode register, both data registers and both latches are 0. The pins equal `port_in` and every readback is 0.
- R9: Register select encoding: 0 is mode, 1 is data 0, 2 is data 1, and 3 selects nothing. Writes to select 3 are ignored and it reads 0. Data bits 7..4 read 0 and are not stored. Mode bits 2, 6 and 7 read 0 and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for readback |
| rd_data | output | 8 | Readback data (combinational) |
| zero_g0 | input | 1 | Group 0 timer reached zero |
| zero_g1 | input | 1 | Group 1 timer reached zero |
| pwm_g0 | input | 1 | Pulse-width waveform for group 0 |
| pwm_g1 | input | 1 | Pulse-width waveform for group 1 |
| port_in | input | 8 | Ordinary port values for pins not in pulse mode |
| pin_out | output | 8 | Pin levels |
| pin_pulse_en | output | 8 | Per-pin pulse-mode flag |

## Verification
The hardest case to reach from the ports is a data write that lands in the same cycle as that group's zero strobe. Here the latch must take the old register value, not the one being written. The stimulus first loads a known value without a strobe. It then raises the write strobe and `zero_g0` in one cycle with a different value, and checks that the pins show the earlier value. One more strobe then brings out the new value. Gating combined with inversion is also reached deliberately: the pulse-width input is held low while inversion is on, so the pins must read all ones.

// File: rtl/step_pkg.sv
// Package: shared types and mode-register bit layout for the stepper
// pattern output block. Assumes an 8-bit register interface.
package step_pkg;

    localparam int REG_W  = 8;
    localparam int B_EN1  = 0;
    localparam int B_EN0  = 1;
    localparam int B_INV0 = 3;
    localparam int B_PWM0 = 4;
    localparam int B_PWM1 = 5;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_DAT0 = 2'd1,
        SEL_DAT1 = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pwm1_en;
        logic pwm0_en;
        logic inv0;
        logic en0;
        logic en1;
    } mode_t;

    // Extract the stored mode fields from a written byte
    function automatic mode_t mode_from_byte(input logic [REG_W-1:0] b);
        mode_t m;
        m.en1     = b[B_EN1];
        m.en0     = b[B_EN0];
        m.inv0    = b[B_INV0];
        m.pwm0_en = b[B_PWM0];
        m.pwm1_en = b[B_PWM1];
        return m;
    endfunction

    // Place the stored mode fields back into a byte; other bits read 0
    function automatic logic [REG_W-1:0] mode_to_byte(input mode_t m);
        logic [REG_W-1:0] b;
        b         = '0;
        b[B_EN1]  = m.en1;
        b[B_EN0]  = m.en0;
        b[B_INV0] = m.inv0;
        b[B_PWM0] = m.pwm0_en;
        b[B_PWM1] = m.pwm1_en;
        return b;
    endfunction

endpackage

// File: rtl/step_regs.sv
// Module: step_regs
// Holds the mode register and the two pattern data registers.
// Stores only the defined bits. Readback is combinational and
// undefined bits read 0. Assumes the synchronous active-low reset.
module step_regs
    import step_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output mode_t            mode_q,
    output logic [NIB_W-1:0] dat0_q,
    output logic [NIB_W-1:0] dat1_q
);

    localparam int PAD_W = REG_W - NIB_W;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Register writes; select 3 is ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dat0_q <= '0;
            dat1_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_MODE: mode_q <= mode_from_byte(wr_data);
                SEL_DAT0: dat0_q <= wr_data[NIB_W-1:0];
                SEL_DAT1: dat1_q <= wr_data[NIB_W-1:0];
                default:  ;
            endcase
        end
    end

    // Readback mux with zero-padded upper bits
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_MODE: rd_data = mode_to_byte(mode_q);
            SEL_DAT0: rd_data = {{PAD_W{1'b0}}, dat0_q};
            SEL_DAT1: rd_data = {{PAD_W{1'b0}}, dat1_q};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/step_group.sv
// Module: step_group
// One group of pattern pins. Latches its pattern on the zero strobe,
// gates it with a pulse-width input, optionally inverts it (only if
// HAS_INV), and selects the port value when not enabled.
// Assumes the zero strobe is one cycle wide and synchronous to clk.
module step_group #(
    parameter int NIB_W   = 4,
    parameter bit HAS_INV = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_stb,
    input  logic [NIB_W-1:0] load_val,
    input  logic             enable,
    input  logic             pwm_en,
    input  logic             pwm_in,
    input  logic             inv,
    input  logic [NIB_W-1:0] port_val,
    output logic [NIB_W-1:0] pin_val,
    output logic [NIB_W-1:0] pin_en
);

    logic [NIB_W-1:0] latch_q;
    logic [NIB_W-1:0] gated;
    logic [NIB_W-1:0] shaped;
    logic             inv_eff;

    // Capture the pattern at the timer zero event
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (zero_stb)
            latch_q <= load_val;
    end

    assign inv_eff = HAS_INV ? inv : 1'b0;

    // Gate, then invert, then choose between pattern and port value
    always_comb begin
        gated   = latch_q & {NIB_W{pwm_in | ~pwm_en}};
        shaped  = gated ^ {NIB_W{inv_eff}};
        pin_val = enable ? shaped : port_val;
        pin_en  = {NIB_W{enable}};
    end

endmodule

// File: rtl/step_pattern_out.sv
// Module: step_pattern_out (top)
// Two groups of stepper pattern pins, loaded on timer zero strobes.
// Group 0 drives pins NIB_W-1..0 and group 1 drives the next NIB_W.
// Assumes the timers outside the block deliver single-cycle zero strobes.
module step_pattern_out
    import step_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [1:0]         rd_sel,
    output logic [REG_W-1:0]   rd_data,
    input  logic               zero_g0,
    input  logic               zero_g1,
    input  logic               pwm_g0,
    input  logic               pwm_g1,
    input  logic [2*NIB_W-1:0] port_in,
    output logic [2*NIB_W-1:0] pin_out,
    output logic [2*NIB_W-1:0] pin_pulse_en
);

    localparam int NGRP = 2;

    mode_t            mode_q;
    logic [NIB_W-1:0] dat0_q;
    logic [NIB_W-1:0] dat1_q;
    logic [NIB_W-1:0] grp_dat  [NGRP];
    logic [NGRP-1:0]  grp_en;
    logic [NGRP-1:0]  grp_pwm_en;
    logic [NGRP-1:0]  grp_pwm;
    logic [NGRP-1:0]  grp_zero;

    step_regs #(.NIB_W(NIB_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .mode_q  (mode_q),
        .dat0_q  (dat0_q),
        .dat1_q  (dat1_q)
    );

    // Spread the mode fields and timer inputs into per-group arrays
    always_comb begin
        grp_dat[0]    = dat0_q;
        grp_dat[1]    = dat1_q;
        grp_en        = {mode_q.en1, mode_q.en0};
        grp_pwm_en    = {mode_q.pwm1_en, mode_q.pwm0_en};
        grp_pwm       = {pwm_g1, pwm_g0};
        grp_zero      = {zero_g1, zero_g0};
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        step_group #(
            .NIB_W   (NIB_W),
            .HAS_INV (g == 0)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .zero_stb (grp_zero[g]),
            .load_val (grp_dat[g]),
            .enable   (grp_en[g]),
            .pwm_en   (grp_pwm_en[g]),
            .pwm_in   (grp_pwm[g]),
            .inv      (mode_q.inv0),
            .port_val (port_in[g*NIB_W +: NIB_W]),
            .pin_val  (pin_out[g*NIB_W +: NIB_W]),
            .pin_en   (pin_pulse_en[g*NIB_W +: NIB_W])
        );
    end

endmodule

// File: rtl/step_chk.sv
// Module: step_chk
// Property checker for step_pattern_out, attached by bind.
module step_chk
    import step_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [1:0]         rd_sel,
    input logic [REG_W-1:0]   rd_data,
    input logic               zero_g0,
    input logic               zero_g1,
    input logic               pwm_g0,
    input logic               pwm_g1,
    input logic [2*NIB_W-1:0] port_in,
    input logic [2*NIB_W-1:0] pin_out,
    input logic [2*NIB_W-1:0] pin_pulse_en,
    input mode_t              mode_q,
    input logic [NIB_W-1:0]   dat0_q,
    input logic [NIB_W-1:0]   dat1_q
);

    logic mode_wr;
    assign mode_wr = wr_en && (wr_sel == SEL_MODE);

    // R2: group 1 shows the latched data after its zero strobe
    a_r2_grp1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_g1 && mode_q.en1 && !mode_q.pwm1_en && !mode_wr)
        |=> pin_out[2*NIB_W-1:NIB_W] == $past(dat1_q));

    // R3: group 0 shows the latched data after its zero strobe
    a_r3_grp0_load: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_g0 && mode_q.en0 && !mode_q.pwm0_en && !mode_q.inv0 && !mode_wr)
        |=> pin_out[NIB_W-1:0] == $past(dat0_q));

    // R4: without a strobe or a mode change, group 1 pins hold
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_g1 && mode_q.en1 && !mode_q.pwm1_en && !mode_wr)
        |=> $stable(pin_out[2*NIB_W-1:NIB_W]));

    // R5: a low pulse-width input forces gated group 0 low
    a_r5_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.en0 && mode_q.pwm0_en && !mode_q.inv0 && !pwm_g0)
        |-> pin_out[NIB_W-1:0] == '0);

    // R6: a low gate with inversion gives all ones on group 0
    a_r6_inv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.en0 && mode_q.pwm0_en && mode_q.inv0 && !pwm_g0)
        |-> pin_out[NIB_W-1:0] == '1);

    // R7: pins not flagged as pulse pins carry the port values
    a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pulse_en[2*NIB_W-1:NIB_W] == '0)
        |-> pin_out[2*NIB_W-1:NIB_W] == port_in[2*NIB_W-1:NIB_W]);

    // R9: data readback has zero upper bits
    a_r9_dat_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_DAT0 || rd_sel == SEL_DAT1)
        |-> rd_data[REG_W-1:NIB_W] == '0);

    // R1: group pulse flags are uniform within each group
    a_r1_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pin_pulse_en[NIB_W-1:0]) == 0
         || $countones(pin_pulse_en[NIB_W-1:0]) == NIB_W));

    logic unused_chk;
    assign unused_chk = pwm_g1;

endmodule

bind step_pattern_out step_chk #(.NIB_W(NIB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .zero_g0      (zero_g0),
    .zero_g1      (zero_g1),
    .pwm_g0       (pwm_g0),
    .pwm_g1       (pwm_g1),
    .port_in      (port_in),
    .pin_out      (pin_out),
    .pin_pulse_en (pin_pulse_en),
    .mode_q       (mode_q),
    .dat0_q       (dat0_q),
    .dat1_q       (dat1_q)
);

// File: tb/sim_step_pattern_out.sv
// Directed bench for step_pattern_out: one task per scenario.
module sim_step_pattern_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       zero_g0 = 1'b0;
    logic       zero_g1 = 1'b0;
    logic       pwm_g0 = 1'b0;
    logic       pwm_g1 = 1'b0;
    logic [7:0] port_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_pulse_en;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    step_pattern_out u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .zero_g0      (zero_g0),
        .zero_g1      (zero_g1),
        .pwm_g0       (pwm_g0),
        .pwm_g1       (pwm_g1),
        .port_in      (port_in),
        .pin_out      (pin_out),
        .pin_pulse_en (pin_pulse_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic zero(input int g);
        if (g == 0) zero_g0 = 1'b1; else zero_g1 = 1'b1;
        step();
        zero_g0 = 1'b0; zero_g1 = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 pins", pin_out, 8'hA5);
        chk("R8 flags", pin_pulse_en, 8'h00);
        rd_chk("R8 mode", 2'd0, 8'h00);
        rd_chk("R8 dat0", 2'd1, 8'h00);
        rd_chk("R8 dat1", 2'd2, 8'h00);
    endtask

    task automatic t_group0();
        wr(2'd0, 8'h02);
        chk("R1 flags g0", pin_pulse_en, 8'h0F);
        chk("R7 g1 port", pin_out, 8'hA0);
        wr(2'd1, 8'hF6);
        rd_chk("R9 dat0 pad", 2'd1, 8'h06);
        chk("R4 no strobe", pin_out, 8'hA0);
        zero(0);
        chk("R3 load", pin_out, 8'hA6);
    endtask

    task automatic t_hold();
        wr(2'd1, 8'h09);
        chk("R4 write only", pin_out, 8'hA6);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h03; zero_g0 = 1'b1;
        step();
        wr_en = 1'b0; zero_g0 = 1'b0;
        chk("R4 same cycle old", pin_out, 8'hA9);
        zero(0);
        chk("R3 next strobe", pin_out, 8'hA3);
    endtask

    task automatic t_group1();
        port_in = 8'h3C;
        wr(2'd0, 8'h01);
        chk("R7 g0 port", pin_out, 8'h0C);
        chk("R1 flags g1", pin_pulse_en, 8'hF0);
        wr(2'd2, 8'h5A);
        zero(1);
        chk("R2 load", pin_out, 8'hAC);
    endtask

    task automatic t_both();
        wr(2'd0, 8'h03);
        chk("R1 both", pin_pulse_en, 8'hFF);
        chk("R1 both pins", pin_out, 8'hA3);
    endtask

    task automatic t_pwm();
        wr(2'd0, 8'h33);
        pwm_g0 = 1'b0; pwm_g1 = 1'b1; #1;
        chk("R5 gate g0 low", pin_out, 8'hA0);
        pwm_g0 = 1'b1; pwm_g1 = 1'b0; #1;
        chk("R5 gate g1 low", pin_out, 8'h03);
    endtask

    task automatic t_pol();
        pwm_g1 = 1'b1;
        wr(2'd0, 8'h0B);
        chk("R6 invert g0 only", pin_out, 8'hAC);
        wr(2'd0, 8'h1B);
        pwm_g0 = 1'b0; #1;
        chk("R6 gate then invert", pin_out, 8'hAF);
        pwm_g0 = 1'b1; #1;
        chk("R6 gate open invert", pin_out, 8'hAC);
    endtask

    task automatic t_readback();
        wr(2'd0, 8'hFF);
        rd_chk("R9 mode bits", 2'd0, 8'h3B);
        wr(2'd3, 8'h55);
        rd_chk("R9 none mode", 2'd0, 8'h3B);
        rd_chk("R9 none dat0", 2'd1, 8'h03);
        rd_chk("R9 none dat1", 2'd2, 8'h0A);
        rd_chk("R9 none read", 2'd3, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_group0();
        t_hold();
        t_group1();
        t_both();
        t_pwm();
        t_pol();
        t_readback();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule